// File: doc/BRIEF.md
# Stretched Reset Output Generator

This block drives one active-low reset line for a supply supervisor. Reset is pulled low while any enabled trigger is present: a voltage monitor fault flag that has its enable bit set, the manual reset pin, or an expiry pulse from a long-period watchdog. When the last trigger goes away, reset stays low for a fixed number of clock cycles, `TIMEOUT_CYCLES`, and then releases. Any trigger that appears during this stretch restarts the full count.

While power-on sequencing is in progress, the block can be set to release reset early. The release happens when a chosen power-up enable from the sequencer goes active. It only applies when reset is already held and no trigger is present. This lets one reset domain leave reset before another. Several copies can serve independent domains. Each copy gets its own mask, its own power-up selection and its own timeout.

The manual reset pin passes through two synchroniser flops. It has no mask bit. On device power-up (`rst_ni` low), reset is held, and it then runs one full timeout before the first release.

Top module: `rst_stretch_gen`

## Requirements
- R1: While `rst_ni` is low, `rst_no` is low. After `rst_ni` rises with no trigger present, `rst_no` rises on exactly the `TIMEOUT_CYCLES`-th clock edge.
- R2: A fault flag `fault_i[k]` whose enable bit `fault_mask_i[k]` is 1 drives `rst_no` low on the next clock edge. `rst_no` stays low for as long as that flag is high.
- R3: A fault flag whose enable bit is 0 has no effect on `rst_no`.
- R4: Once every trigger is gone, `rst_no` rises after exactly `TIMEOUT_CYCLES` consecutive trigger-free edges. A trigger present at any edge during this stretch restarts the full count.
- R5: The manual reset pin `mreset_ni` (active low) passes through two synchroniser flops and cannot be masked. A low level held for 3 or more edges pulls `rst_no` low on the third edge. After the pin returns high, `rst_no` releases `TIMEOUT_CYCLES + 2` edges later.
- R6: An expiry pulse `wdt_expire_i` seen while `wdt_en_i` is 1 drives `rst_no` low on the next edge. It is then released `TIMEOUT_CYCLES` edges after the pulse ends. With `wdt_en_i` at 0 the pulse has no effect.
- R7: Early release happens when all of these hold at a clock edge: `seq_on_i` = 1, `early_en_i` = 1, reset is held, no trigger is present, and bit `pup_i[pup_sel_i]` is 1 at this edge after being 0 at the previous edge. `rst_no` then rises on that edge.
- R8: Early release does not happen if any of these is true: `seq_on_i` is 0, `early_en_i` is 0, a trigger is present, or the bit that rose is not the one selected by `pup_sel_i`. In each of these cases reset stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous device power-up reset, active low |
| fault_i | input | N_MON | Under/over-voltage fault flags, active high |
| fault_mask_i | input | N_MON | Per-flag enable as a reset source, 1 = enabled |
| mreset_ni | input | 1 | Manual reset pin, active low, asynchronous |
| wdt_en_i | input | 1 | Long watchdog enable as a reset source |
| wdt_expire_i | input | 1 | Long watchdog expiry, active high |
| seq_on_i | input | 1 | High during power-on sequencing |
| early_en_i | input | 1 | Enable for early release |
| pup_sel_i | input | SEL_W | Index of the power-up enable used for early release |
| pup_i | input | N_PUP | Power-up enables from the sequencer |
| rst_no | output | 1 | Stretched reset output, active low |

## Verification
A wrong counter value, or a hold flag left set by mistake, shows at `rst_no` as a release that comes at the wrong edge. It can also show as a release while a trigger is still present. So every release is timed to the exact edge, and the bench never accepts a window. A stale value in the edge register of the power-up input shows up within one edge: either a missed early release or an early release that should not have happened. The sweep therefore crosses every selection value with every power-up bit. The two synchroniser stages account for the two extra edges in the manual reset timing. A missing or extra stage shifts both the assertion edge and the release edge by one.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  typedef enum logic {
    RST_RELEASED = 1'b0,
    RST_HELD     = 1'b1
  } rst_state_e;

  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsg_trig.sv
module rsg_trig #(
  parameter int N_MON = 6
) (
  input  logic [N_MON-1:0] fault_i,
  input  logic [N_MON-1:0] fault_mask_i,
  input  logic             mreset_sync_ni,
  input  logic             wdt_en_i,
  input  logic             wdt_expire_i,
  output logic             trig_o
);
  logic [N_MON-1:0] fault_hit;

  generate
    for (genvar k = 0; k < N_MON; k++) begin : g_mon
      assign fault_hit[k] = fault_i[k] & fault_mask_i[k];
    end
  endgenerate

  // manual reset has no mask by design
  assign trig_o = (|fault_hit) | ~mreset_sync_ni | (wdt_en_i & wdt_expire_i);
endmodule

// File: rtl/rsg_early.sv
module rsg_early #(
  parameter int N_PUP = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PUP-1:0] pup_i,
  input  logic [SEL_W-1:0] pup_sel_i,
  input  logic             seq_on_i,
  input  logic             early_en_i,
  output logic             early_o
);
  logic [N_PUP-1:0] pup_q;
  logic             sel_now, sel_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pup_q <= '0;
    else         pup_q <= pup_i;
  end

  always_comb begin
    sel_now  = 1'b0;
    sel_prev = 1'b0;
    for (int i = 0; i < N_PUP; i++) begin
      if (SEL_W'(i) == pup_sel_i) begin
        sel_now  = pup_i[i];
        sel_prev = pup_q[i];
      end
    end
  end

  assign early_o = seq_on_i & early_en_i & sel_now & ~sel_prev;
endmodule

// File: rtl/rsg_timer.sv
module rsg_timer
  import rsg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16,
  localparam int CNT_W = cnt_width(TIMEOUT_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic early_i,
  output logic rst_no
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  rst_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RST_HELD;
      cnt_q   <= '0;
    end else if (trig_i) begin
      state_q <= RST_HELD;
      cnt_q   <= '0;
    end else if (state_q == RST_HELD) begin
      if (early_i || cnt_q == LAST) begin
        state_q <= RST_RELEASED;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_no = (state_q == RST_RELEASED);
endmodule

// File: rtl/rst_stretch_gen.sv
module rst_stretch_gen #(
  parameter int N_MON          = 6,
  parameter int N_PUP          = 4,
  parameter int TIMEOUT_CYCLES = 16,
  localparam int SEL_W = (N_PUP > 1) ? $clog2(N_PUP) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MON-1:0] fault_i,
  input  logic [N_MON-1:0] fault_mask_i,
  input  logic             mreset_ni,
  input  logic             wdt_en_i,
  input  logic             wdt_expire_i,
  input  logic             seq_on_i,
  input  logic             early_en_i,
  input  logic [SEL_W-1:0] pup_sel_i,
  input  logic [N_PUP-1:0] pup_i,
  output logic             rst_no
);
  logic mreset_sync_n, trig, early;

  rsg_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mreset_ni), .q_o(mreset_sync_n)
  );

  rsg_trig #(.N_MON(N_MON)) u_trig (
    .fault_i(fault_i), .fault_mask_i(fault_mask_i), .mreset_sync_ni(mreset_sync_n),
    .wdt_en_i(wdt_en_i), .wdt_expire_i(wdt_expire_i), .trig_o(trig)
  );

  rsg_early #(.N_PUP(N_PUP), .SEL_W(SEL_W)) u_early (
    .clk_i(clk_i), .rst_ni(rst_ni), .pup_i(pup_i), .pup_sel_i(pup_sel_i),
    .seq_on_i(seq_on_i), .early_en_i(early_en_i), .early_o(early)
  );

  rsg_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig), .early_i(early), .rst_no(rst_no)
  );
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int N_MON = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MON-1:0] fault_i,
  input logic [N_MON-1:0] fault_mask_i,
  input logic             mreset_ni,
  input logic             wdt_en_i,
  input logic             wdt_expire_i,
  input logic             rst_no
);
  logic fault_act, wdt_act;
  assign fault_act = |(fault_i & fault_mask_i);
  assign wdt_act   = wdt_en_i & wdt_expire_i;

  AST_FAULT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_act |=> !rst_no); // R2

  AST_WDT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_act |=> !rst_no); // R6

  AST_MR_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreset_ni && $past(!mreset_ni) && $past(!mreset_ni, 2)) |=> !rst_no); // R5

  AST_RISE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (!$past(fault_act) && !$past(wdt_act))); // R4
endmodule

bind rst_stretch_gen rsg_checker #(.N_MON(N_MON)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .fault_mask_i(fault_mask_i),
  .mreset_ni(mreset_ni), .wdt_en_i(wdt_en_i), .wdt_expire_i(wdt_expire_i), .rst_no(rst_no)
);

// File: tb/rst_stretch_gen_tb.sv
`timescale 1ns/1ps
module rst_stretch_gen_tb_top;
  localparam int NM = 6;
  localparam int NP = 4;
  localparam int T  = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [NM-1:0] fault_i, fault_mask_i;
  logic          mreset_ni, wdt_en_i, wdt_expire_i, seq_on_i, early_en_i;
  logic [1:0]    pup_sel_i;
  logic [NP-1:0] pup_i;
  logic          rst_no;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rst_stretch_gen #(.N_MON(NM), .N_PUP(NP), .TIMEOUT_CYCLES(T)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .fault_i(fault_i), .fault_mask_i(fault_mask_i),
    .mreset_ni(mreset_ni), .wdt_en_i(wdt_en_i), .wdt_expire_i(wdt_expire_i),
    .seq_on_i(seq_on_i), .early_en_i(early_en_i), .pup_sel_i(pup_sel_i),
    .pup_i(pup_i), .rst_no(rst_no)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // edges until rst_no rises
  task automatic measure(output int n);
    n = 0;
    while (rst_no == 1'b0 && n < 200) begin
      step(1);
      n++;
    end
  endtask

  task automatic wdt_pulse();
    wdt_en_i = 1'b1; wdt_expire_i = 1'b1;
    step(1);
    wdt_expire_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    rst_ni = 1'b0; fault_i = '0; fault_mask_i = '0; mreset_ni = 1'b1;
    wdt_en_i = 1'b0; wdt_expire_i = 1'b0; seq_on_i = 1'b0; early_en_i = 1'b0;
    pup_sel_i = '0; pup_i = '0;
    step(3);
    chk(rst_no == 1'b0, "R1 held in reset", int'(rst_no), 0);
    rst_ni = 1'b1;
    measure(n);
    chk(n == T, "R1 power-up stretch", n, T);

    // fault sweep: every flag, enable on and off
    for (int i = 0; i < NM; i++) begin
      for (int m = 0; m < 2; m++) begin
        fault_mask_i = NM'(m) << i;
        fault_i = NM'(1) << i;
        step(1);
        if (m == 1) chk(rst_no == 1'b0, "R2 fault asserts", int'(rst_no), 0);
        else        chk(rst_no == 1'b1, "R3 masked fault ignored", int'(rst_no), 1);
        step(3);
        if (m == 1) chk(rst_no == 1'b0, "R2 held while fault", int'(rst_no), 0);
        else        chk(rst_no == 1'b1, "R3 masked fault held ignored", int'(rst_no), 1);
        fault_i = '0;
        if (m == 1) begin
          measure(n);
          chk(n == T, "R4 release after fault", n, T);
        end
        fault_mask_i = '0;
      end
    end

    // retrigger mid-stretch
    fault_mask_i = 6'b000001; fault_i = 6'b000001;
    step(2);
    fault_i = '0;
    step(4);
    chk(rst_no == 1'b0, "R4 still stretching", int'(rst_no), 0);
    fault_i = 6'b000001;
    step(1);
    fault_i = '0;
    measure(n);
    chk(n == T, "R4 retrigger reload", n, T);
    fault_mask_i = '0;

    // manual reset, nothing enabled
    mreset_ni = 1'b0;
    step(2);
    chk(rst_no == 1'b1, "R5 sync latency", int'(rst_no), 1);
    step(1);
    chk(rst_no == 1'b0, "R5 manual asserts", int'(rst_no), 0);
    step(3);
    mreset_ni = 1'b1;
    measure(n);
    chk(n == T + 2, "R5 manual release", n, T + 2);

    // long watchdog
    wdt_pulse();
    chk(rst_no == 1'b0, "R6 watchdog asserts", int'(rst_no), 0);
    measure(n);
    chk(n == T, "R6 watchdog release", n, T);
    wdt_en_i = 1'b0; wdt_expire_i = 1'b1;
    step(3);
    chk(rst_no == 1'b1, "R6 disabled watchdog ignored", int'(rst_no), 1);
    wdt_expire_i = 1'b0;

    // early release: every selection against every bit
    seq_on_i = 1'b1; early_en_i = 1'b1;
    for (int s = 0; s < NP; s++) begin
      for (int b = 0; b < NP; b++) begin
        pup_sel_i = 2'(s);
        wdt_pulse();
        step(1);
        pup_i = NP'(1) << b;
        step(1);
        if (b == s) chk(rst_no == 1'b1, "R7 early release", int'(rst_no), 1);
        else        chk(rst_no == 1'b0, "R8 unselected bit ignored", int'(rst_no), 0);
        pup_i = '0;
        measure(n);
      end
    end

    // gating cases
    pup_sel_i = 2'd1;
    early_en_i = 1'b0;
    wdt_pulse(); step(1);
    pup_i = 4'b0010; step(1);
    chk(rst_no == 1'b0, "R8 early disabled", int'(rst_no), 0);
    pup_i = '0; measure(n);
    early_en_i = 1'b1; seq_on_i = 1'b0;
    wdt_pulse(); step(1);
    pup_i = 4'b0010; step(1);
    chk(rst_no == 1'b0, "R8 outside sequencing", int'(rst_no), 0);
    pup_i = '0; measure(n);
    seq_on_i = 1'b1;
    fault_mask_i = 6'b000100; fault_i = 6'b000100;
    step(1);
    pup_i = 4'b0010; step(1);
    chk(rst_no == 1'b0, "R8 trigger blocks early", int'(rst_no), 0);
    fault_i = '0; pup_i = '0;
    measure(n);
    chk(n == T, "R8 normal release after blocked early", n, T);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule